// File: doc/BRIEF.md
# Processor Bus Command Controller

This block sits beside a processor and turns its 3-bit bus status code into timed command and control strobes. A change from the passive code to any active code starts a bus cycle. The block then runs that cycle through three phases on the processor clock: an address phase, an early command phase and a late command phase. In the address phase it pulses the address-latch enable. In the command phases it drives the active-low command lines, the data-transceiver enable and the data direction. A return to the passive code ends the cycle.

Three inputs gate the outputs. A command-enable input masks every command and the transceiver enable. An active-low address-enable input controls the output enable of each command line. The enable is granted only after a parameterised number of clock cycles and is withdrawn at once when address-enable is released. A strapped mode input selects I/O-bus mode, in which the I/O command lines ignore address-enable. Each command line has its own output-enable flag, so the system can model tri-state drivers.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The status code is decoded as follows. 000 is interrupt acknowledge (cmd bit 6). 001 is I/O read (bit 3). 010 is I/O write (bits 5 and 4). 011 is halt. 100 and 101 are memory read (bit 0). 110 is memory write (bits 2 and 1). 111 is passive. The command vector holds memory read at bit 0, memory write at bit 1, advanced memory write at bit 2, I/O read at bit 3, I/O write at bit 4, advanced I/O write at bit 5 and interrupt acknowledge at bit 6. Every command bit is active low.
- R2: If the status is passive during a command phase or while idle, all seven command bits are high on the next cycle, and the address-latch enable stays low.
- R3: When a non-passive code arrives while idle, the address-latch enable is high for exactly one cycle, the one after the clock edge that sees the code. No command is active in that cycle.
- R4: Read, interrupt-acknowledge and advanced-write commands go low in the cycle after the address-latch pulse. The normal memory and I/O writes go low one cycle later. All of them stay low until the passive code ends the cycle.
- R5: Data enable is high in both command phases for every code except halt. Halt produces no command and no data enable.
- R6: Data direction is high (transmit) from the address phase through the command phases of a write code (010 or 110). It is low for every other code and while idle.
- R7: While command-enable is low, all command bits are high and data enable is low.
- R8: After address-enable goes low, the output-enable bits of address-gated lines become 1 only once AEN_DLY rising edges have seen it low.
- R9: When address-enable goes high, every address-gated output-enable bit is 0 in the same cycle, with no clock edge needed.
- R10: With the mode input high, the output-enable bits 3 to 5 (the I/O lines) are 1 whatever the state of address-enable. Bits 0, 1, 2 and 6 stay address-gated.
- R11: After reset, all command bits are high, address-latch enable and data enable are low, and the delay count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | 3 | Processor bus status code |
| cmd_en_i | input | 1 | Command enable; low masks commands and data enable |
| addr_en_n_i | input | 1 | Address enable, active low, gates command output enables |
| io_mode_i | input | 1 | Strap: high selects I/O-bus mode |
| ale_o | output | 1 | Address-latch enable, active high |
| den_o | output | 1 | Data-transceiver enable, active high |
| dt_tx_o | output | 1 | Data direction: high transmit, low receive |
| cmd_n_o | output | 7 | Active-low command lines (bit map in R1) |
| cmd_oe_o | output | 7 | Per-line output enable for the command lines |

## Verification
The bench builds the block with AEN_DLY = 3. This value is small enough that a single directed test can check the enable at each count below the limit and again at the limit. It is also large enough that an off-by-one in the counter shows up as a wrong output-enable value in a specific cycle. With this setting the whole status table, a cycle under command masking, the immediate release on address-enable and the I/O-mode bypass each take only a few cycles.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_EARLY = 2'd2,
        PH_LATE  = 2'd3
    } bus_phase_e;

    localparam logic [2:0] ST_INTA    = 3'b000;
    localparam logic [2:0] ST_IORD    = 3'b001;
    localparam logic [2:0] ST_IOWR    = 3'b010;
    localparam logic [2:0] ST_HALT    = 3'b011;
    localparam logic [2:0] ST_FETCH   = 3'b100;
    localparam logic [2:0] ST_MRD     = 3'b101;
    localparam logic [2:0] ST_MWR     = 3'b110;
    localparam logic [2:0] ST_PASSIVE = 3'b111;

    localparam int CMD_W    = 7;
    localparam int C_MRD    = 0;
    localparam int C_MWR    = 1;
    localparam int C_AMWR   = 2;
    localparam int C_IORD   = 3;
    localparam int C_IOWR   = 4;
    localparam int C_AIOWR  = 5;
    localparam int C_INTA   = 6;

    typedef struct packed {
        logic inta;
        logic iord;
        logic iowr;
        logic mrd;
        logic mwr;
        logic halt;
        logic write;
    } stat_dec_t;
endpackage

// File: rtl/bus_stat_decode.sv
module bus_stat_decode
    import bus_cmd_pkg::*;
(
    input  logic [2:0] code_i,
    output stat_dec_t  dec_o
);
    always_comb begin
        dec_o       = '0;
        dec_o.inta  = (code_i == ST_INTA);
        dec_o.iord  = (code_i == ST_IORD);
        dec_o.iowr  = (code_i == ST_IOWR);
        dec_o.halt  = (code_i == ST_HALT);
        dec_o.mrd   = (code_i == ST_FETCH) || (code_i == ST_MRD);
        dec_o.mwr   = (code_i == ST_MWR);
        dec_o.write = dec_o.iowr || dec_o.mwr;
    end
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
    import bus_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] stat_i,
    output bus_phase_e phase_o,
    output logic [2:0] code_o
);
    typedef struct packed {
        bus_phase_e phase;
        logic [2:0] code;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (stat_i != ST_PASSIVE) begin
                    seq_d.phase = PH_ADDR;
                    seq_d.code  = stat_i;
                end
            end
            PH_ADDR:  seq_d.phase = PH_EARLY;
            PH_EARLY: seq_d.phase = (stat_i == ST_PASSIVE) ? PH_IDLE : PH_LATE;
            PH_LATE:  seq_d.phase = (stat_i == ST_PASSIVE) ? PH_IDLE : PH_LATE;
            default:  seq_d.phase = PH_IDLE;
        endcase
        if (seq_d.phase == PH_IDLE) seq_d.code = ST_PASSIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.code  <= ST_PASSIVE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign code_o  = seq_q.code;

    // R3
    addr_phase_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ADDR) |=> (seq_q.phase == PH_EARLY));
endmodule

// File: rtl/bus_aen_gate.sv
module bus_aen_gate #(
    parameter int AEN_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_en_n_i,
    output logic rdy_o
);
    localparam int CW = (AEN_DLY < 1) ? 1 : $clog2(AEN_DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(AEN_DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (addr_en_n_i)        cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rdy_o = !addr_en_n_i && (cnt_q == LIMIT);

    generate
        if (AEN_DLY > 0) begin : g_dly_chk
            // R8
            aen_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rdy_o |-> $past(!addr_en_n_i));
        end
    endgenerate
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
    import bus_cmd_pkg::*;
#(
    parameter int AEN_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       stat_i,
    input  logic             cmd_en_i,
    input  logic             addr_en_n_i,
    input  logic             io_mode_i,
    output logic             ale_o,
    output logic             den_o,
    output logic             dt_tx_o,
    output logic [CMD_W-1:0] cmd_n_o,
    output logic [CMD_W-1:0] cmd_oe_o
);
    bus_phase_e       phase;
    logic [2:0]       code;
    stat_dec_t        dec;
    logic             gate_rdy;
    logic             io_ok;
    logic             early, late;
    logic [CMD_W-1:0] act;

    bus_phase_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_i),
        .phase_o(phase),
        .code_o (code)
    );

    bus_stat_decode u_dec (
        .code_i(code),
        .dec_o (dec)
    );

    bus_aen_gate #(.AEN_DLY(AEN_DLY)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_en_n_i(addr_en_n_i),
        .rdy_o      (gate_rdy)
    );

    always_comb begin
        early = (phase == PH_EARLY) || (phase == PH_LATE);
        late  = (phase == PH_LATE);
        act          = '0;
        act[C_MRD]   = early && dec.mrd;
        act[C_MWR]   = late  && dec.mwr;
        act[C_AMWR]  = early && dec.mwr;
        act[C_IORD]  = early && dec.iord;
        act[C_IOWR]  = late  && dec.iowr;
        act[C_AIOWR] = early && dec.iowr;
        act[C_INTA]  = early && dec.inta;
    end

    assign io_ok   = io_mode_i || gate_rdy;
    assign cmd_n_o = ~(act & {CMD_W{cmd_en_i}});
    assign ale_o   = (phase == PH_ADDR);
    assign den_o   = early && !dec.halt && cmd_en_i;
    assign dt_tx_o = (phase != PH_IDLE) && dec.write;

    always_comb begin
        for (int i = 0; i < CMD_W; i++) begin
            cmd_oe_o[i] = (i >= C_IORD && i <= C_AIOWR) ? io_ok : gate_rdy;
        end
    end

    // R2
    passive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i == ST_PASSIVE && phase != PH_ADDR) |=> (&cmd_n_o && !ale_o));

    // R3
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R4
    late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_n_o[C_MWR] && $past(cmd_en_i)) |-> $past(!cmd_n_o[C_AMWR]));

    // R1
    cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cmd_n_o) <= 2);
endmodule

// File: tb/sim_bus_cmd_ctrl.sv
module sim_bus_cmd_ctrl;
    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat_i = 3'b111;
    logic       cmd_en_i = 1'b1;
    logic       addr_en_n_i = 1'b0;
    logic       io_mode_i = 1'b0;
    logic       ale_o, den_o, dt_tx_o;
    logic [6:0] cmd_n_o, cmd_oe_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_cmd_ctrl #(.AEN_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .cmd_en_i(cmd_en_i),
        .addr_en_n_i(addr_en_n_i), .io_mode_i(io_mode_i), .ale_o(ale_o),
        .den_o(den_o), .dt_tx_o(dt_tx_o), .cmd_n_o(cmd_n_o), .cmd_oe_o(cmd_oe_o)
    );

    // fields: code[18:16], early cmd[15:9], late cmd[8:2], den[1], dt[0]
    localparam logic [18:0] VEC [0:7] = '{
        {3'b000, 7'h3F, 7'h3F, 1'b1, 1'b0},
        {3'b001, 7'h77, 7'h77, 1'b1, 1'b0},
        {3'b010, 7'h5F, 7'h4F, 1'b1, 1'b1},
        {3'b011, 7'h7F, 7'h7F, 1'b0, 1'b0},
        {3'b100, 7'h7E, 7'h7E, 1'b1, 1'b0},
        {3'b101, 7'h7E, 7'h7E, 1'b1, 1'b0},
        {3'b110, 7'h7B, 7'h79, 1'b1, 1'b1},
        {3'b010, 7'h5F, 7'h4F, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        // R11 reset state
        chk("R11 cmd", cmd_n_o, 7'h7F);
        chk("R11 ale/den", {5'b0, ale_o, den_o}, 7'h00);
        rst_n = 1'b1;
        repeat (DLY + 2) step();
        chk("R8 oe after wait", cmd_oe_o, 7'h7F);

        // R2 passive held: nothing happens
        step();
        chk("R2 passive cmd", cmd_n_o, 7'h7F);
        chk("R2 passive ale", {6'b0, ale_o}, 7'h00);

        // Table walk: R1 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            stat_i = VEC[v][18:16];
            step();
            chk("R3 ale high", {6'b0, ale_o}, 7'h01);
            chk("R3 no cmd in addr", cmd_n_o, 7'h7F);
            step();
            chk("R1 R4 early cmd", cmd_n_o, VEC[v][15:9]);
            chk("R5 den", {6'b0, den_o}, {6'b0, VEC[v][1]});
            chk("R6 dt", {6'b0, dt_tx_o}, {6'b0, VEC[v][0]});
            step();
            chk("R4 late cmd", cmd_n_o, VEC[v][8:2]);
            stat_i = 3'b111;
            step();
            chk("R2 release", cmd_n_o, 7'h7F);
            chk("R6 dt idle", {5'b0, ale_o, dt_tx_o}, 7'h00);
        end

        // R7 command-enable masking
        cmd_en_i = 1'b0;
        stat_i = 3'b110;
        step(); step(); step();
        chk("R7 masked cmd", cmd_n_o, 7'h7F);
        chk("R7 masked den", {6'b0, den_o}, 7'h00);
        cmd_en_i = 1'b1;
        #1;
        chk("R7 unmask", cmd_n_o, 7'h79);
        stat_i = 3'b111;
        step();

        // R9 immediate release
        addr_en_n_i = 1'b1;
        #1;
        chk("R9 oe drop", cmd_oe_o, 7'h00);
        @(negedge clk);
        // R8 delay count
        addr_en_n_i = 1'b0;
        step();
        chk("R8 oe after 1 edge", cmd_oe_o, 7'h00);
        step();
        chk("R8 oe after 2 edges", cmd_oe_o, 7'h00);
        step();
        chk("R8 oe after 3 edges", cmd_oe_o, 7'h7F);

        // R10 I/O-bus mode bypass
        io_mode_i = 1'b1;
        addr_en_n_i = 1'b1;
        #1;
        chk("R10 io oe kept", cmd_oe_o, 7'h38);
        io_mode_i = 1'b0;
        #1;
        chk("R10 sys mode oe", cmd_oe_o, 7'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule